// File: doc/BRIEF.md
# Nametable Mirroring Selector

This block sits on the video address path and turns a nametable address into a physical location. The nametable window holds four logical slots of 1 KB each. Each slot is steered to one of two internal 1 KB RAM banks, or to one half of an external 2 KB region that a cartridge may supply for four independent screens. The result is a physical page select, a 10-bit offset within the page, and a flag that says whether the page is internal or external. The RAM arrays themselves sit outside the block.

The mapping is held in a small per-slot table. Three kinds of update write to it:
- A configuration load applies the cartridge's fixed setup: a four-screen flag, a hardwired-lock flag and an initial mirroring mode.
- A mirroring-mode write picks one of four standard arrangements. These are horizontal, vertical, single-screen low and single-screen high.
- A per-slot map write gives each slot an arbitrary page number.

When the lock is set, mirroring-mode writes are dropped. This is how a board with soldered mirroring refuses software changes.

Address lookups flow through a valid/ready stream with one register stage. A request is accepted when `req_valid` and `req_ready` are both high. Its response appears on the next cycle with `rsp_valid` high. The response stays unchanged while `rsp_ready` is low. `req_ready` is low only while a response is held and not yet taken.

Top module: `nt_mirror_sel`

## Requirements
- R1: After reset the table is horizontal, unlocked and all internal. No response is pending (`rsp_valid`=0) and `req_ready`=1.
- R2: The slot is `req_addr[11:10]`. `rsp_off` equals `req_addr[9:0]` of the accepted request.
- R3: Mode code 0 (horizontal) maps slots 0 and 1 to page 0, and slots 2 and 3 to page 1. All four slots are internal.
- R4: Mode code 1 (vertical) maps slots 0 and 2 to page 0, and slots 1 and 3 to page 1. All four slots are internal.
- R5: Mode code 2 maps every slot to internal page 0. Mode code 3 maps every slot to internal page 1.
- R6: A configuration load with `cfg_four`=1 maps slots 0 and 1 to internal pages 0 and 1, and slots 2 and 3 to external pages 0 and 1 (`rsp_ext`=1). `cfg_mode` is then not used.
- R7: A configuration load sets the lock to `cfg_lock`. While the lock is set, a mirroring-mode write changes nothing. A later configuration load with `cfg_lock`=0 removes the lock.
- R8: A mirroring-mode write that takes effect marks all four slots internal.
- R9: A map write sets the page of slot i to `map_pages[2i+1:2i]`. It leaves every slot's internal/external flag unchanged, and the lock does not block it.
- R10: When strobes coincide, a configuration load wins over a mode write, and a mode write wins over a map write. The strobe that loses is dropped.
- R11: A response is due exactly one cycle after acceptance. It is held stable while `rsp_ready`=0, and `req_ready` is 0 during that time. Table writes take effect for requests accepted on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Apply the cartridge configuration |
| cfg_four | input | 1 | Four-screen layout at configuration |
| cfg_lock | input | 1 | Hardwired lock at configuration |
| cfg_mode | input | 2 | Mirroring mode at configuration |
| mode_wr | input | 1 | Mirroring-mode write strobe |
| mode_sel | input | 2 | Mirroring mode code (0 horizontal, 1 vertical, 2 single low, 3 single high) |
| map_wr | input | 1 | Per-slot map write strobe |
| map_pages | input | 8 | Page for slot i in bits 2i+1:2i |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle when valid |
| req_addr | input | 12 | Nametable address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_bank | output | 2 | Physical page select |
| rsp_off | output | 10 | Offset within the page |
| rsp_ext | output | 1 | 1 when the page is in the external region |

## Verification
Each table write takes one clock edge to reach the table. The lookup result is registered on the edge that accepts the request. So a response reflects writes made before the cycle of acceptance, and it is valid one edge after acceptance. Every scenario task drives inputs on the falling edge and issues lookups only after its writes are complete. It samples the response on the next falling edge, half a cycle after the edge that loaded it. The stall scenario adds checks on the falling edges that follow. It confirms that a held response and a low `req_ready` persist cycle by cycle until `rsp_ready` returns.

// File: rtl/nt_mirror_pkg.sv
package nt_mirror_pkg;

  localparam int SLOT_BITS = 2;
  localparam int NSLOT     = 1 << SLOT_BITS;
  localparam int PAGE_W    = 2;

  typedef enum logic [1:0] {
    MIR_HORZ   = 2'd0,
    MIR_VERT   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mir_mode_e;

  typedef struct packed {
    logic              ext;
    logic [PAGE_W-1:0] page;
  } slot_map_t;

  // Page picked for a slot by a standard mirroring arrangement.
  function automatic logic [PAGE_W-1:0] mode_page(mir_mode_e m, logic [SLOT_BITS-1:0] s);
    logic [PAGE_W-1:0] p;
    p = '0;
    case (m)
      MIR_HORZ:   p[0] = s[SLOT_BITS-1];
      MIR_VERT:   p[0] = s[0];
      MIR_ONE_LO: p[0] = 1'b0;
      MIR_ONE_HI: p[0] = 1'b1;
      default:    p[0] = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/nt_map_table.sv
module nt_map_table
  import nt_mirror_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_four,
  input  logic                    cfg_lock,
  input  logic [1:0]              cfg_mode,
  input  logic                    mode_wr,
  input  logic [1:0]              mode_sel,
  input  logic                    map_wr,
  input  logic [NSLOT*PAGE_W-1:0] map_pages,
  output slot_map_t               tbl_o [NSLOT],
  output logic                    lock_o
);

  logic lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (cfg_load) lock_q <= cfg_lock;
  end

  assign lock_o = lock_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [SLOT_BITS-1:0] SIDX = SLOT_BITS'(i);
    slot_map_t cur_q, nxt;

    always_comb begin
      nxt = cur_q;
      if (cfg_load) begin
        if (cfg_four) begin
          nxt.ext  = SIDX[SLOT_BITS-1];
          nxt.page = PAGE_W'(SIDX[0]);
        end else begin
          nxt.ext  = 1'b0;
          nxt.page = mode_page(mir_mode_e'(cfg_mode), SIDX);
        end
      end else if (mode_wr) begin
        if (!lock_q) begin
          nxt.ext  = 1'b0;
          nxt.page = mode_page(mir_mode_e'(mode_sel), SIDX);
        end
      end else if (map_wr) begin
        nxt.page = map_pages[i*PAGE_W +: PAGE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_q.ext  <= 1'b0;
        cur_q.page <= mode_page(MIR_HORZ, SIDX);
      end else begin
        cur_q <= nxt;
      end
    end

    assign tbl_o[i] = cur_q;
  end

endmodule

// File: rtl/nt_lookup_stage.sv
module nt_lookup_stage
  import nt_mirror_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  slot_map_t                  tbl_i [NSLOT],
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [OFF_W+SLOT_BITS-1:0] req_addr,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [PAGE_W-1:0]          rsp_bank,
  output logic [OFF_W-1:0]           rsp_off,
  output logic                       rsp_ext
);

  logic [SLOT_BITS-1:0] slot;
  slot_map_t            sel;
  logic                 vld_q;

  assign slot      = req_addr[OFF_W +: SLOT_BITS];
  assign sel       = tbl_i[slot];
  assign req_ready = !vld_q || rsp_ready;
  assign rsp_valid = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      rsp_bank <= '0;
      rsp_off  <= '0;
      rsp_ext  <= 1'b0;
    end else if (req_ready) begin
      vld_q <= req_valid;
      if (req_valid) begin
        rsp_bank <= sel.page;
        rsp_ext  <= sel.ext;
        rsp_off  <= req_addr[OFF_W-1:0];
      end
    end
  end

endmodule

// File: rtl/nt_mirror_sel.sv
module nt_mirror_sel
  import nt_mirror_pkg::*;
#(
  parameter int OFF_W = 10,
  localparam int AW   = OFF_W + SLOT_BITS,
  localparam int MW   = NSLOT * PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_four,
  input  logic              cfg_lock,
  input  logic [1:0]        cfg_mode,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic              map_wr,
  input  logic [MW-1:0]     map_pages,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PAGE_W-1:0] rsp_bank,
  output logic [OFF_W-1:0]  rsp_off,
  output logic              rsp_ext
);

  slot_map_t        tbl [NSLOT];
  logic             lock_q;
  logic [NSLOT-1:0] slot_ext;
  logic [MW-1:0]    slot_pages;

  nt_map_table u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_four  (cfg_four),
    .cfg_lock  (cfg_lock),
    .cfg_mode  (cfg_mode),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .map_wr    (map_wr),
    .map_pages (map_pages),
    .tbl_o     (tbl),
    .lock_o    (lock_q)
  );

  nt_lookup_stage #(.OFF_W(OFF_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_i     (tbl),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_bank  (rsp_bank),
    .rsp_off   (rsp_off),
    .rsp_ext   (rsp_ext)
  );

  // Flattened views of the table for the bound checker.
  for (genvar i = 0; i < NSLOT; i++) begin : g_flat
    assign slot_ext[i]                   = tbl[i].ext;
    assign slot_pages[i*PAGE_W +: PAGE_W] = tbl[i].page;
  end

endmodule

// File: rtl/nt_mirror_chk.sv
module nt_mirror_chk
  import nt_mirror_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_load,
  input logic                       cfg_four,
  input logic                       mode_wr,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [OFF_W+SLOT_BITS-1:0] req_addr,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [PAGE_W-1:0]          rsp_bank,
  input logic [OFF_W-1:0]           rsp_off,
  input logic                       rsp_ext,
  input logic                       lock_q,
  input logic [NSLOT-1:0]           slot_ext,
  input logic [NSLOT*PAGE_W-1:0]    slot_pages
);

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bank) && $stable(rsp_off) && $stable(rsp_ext));

  a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid && rsp_off == $past(req_addr[OFF_W-1:0]));

  a_r8_mode_internal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !cfg_load && !lock_q |=> slot_ext == '0);

  a_r7_lock_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !cfg_load && lock_q |=> $stable(slot_pages) && $stable(slot_ext));

  a_r6_four_half_ext: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && cfg_four |=> $countones(slot_ext) == NSLOT/2);

endmodule

bind nt_mirror_sel nt_mirror_chk #(.OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .cfg_four   (cfg_four),
  .mode_wr    (mode_wr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_bank   (rsp_bank),
  .rsp_off    (rsp_off),
  .rsp_ext    (rsp_ext),
  .lock_q     (lock_q),
  .slot_ext   (slot_ext),
  .slot_pages (slot_pages)
);

// File: tb/test_nt_mirror_sel.sv
module test_nt_mirror_sel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_four = 1'b0, cfg_lock = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        map_wr = 1'b0;
  logic [7:0]  map_pages = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = 12'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_bank;
  logic [9:0]  rsp_off;
  logic        rsp_ext;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nt_mirror_sel i_nt_mirror_sel (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_four(cfg_four), .cfg_lock(cfg_lock), .cfg_mode(cfg_mode),
    .mode_wr(mode_wr), .mode_sel(mode_sel),
    .map_wr(map_wr), .map_pages(map_pages),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_bank(rsp_bank), .rsp_off(rsp_off), .rsp_ext(rsp_ext)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One lookup; response sampled on the falling edge after acceptance (R11).
  task automatic lookup(string tag, int slot, int off, int exp_bank, int exp_ext);
    @(negedge clk);
    req_valid = 1'b1;
    rsp_ready = 1'b1;
    req_addr  = {slot[1:0], off[9:0]};
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R11 rsp_valid"}, rsp_valid, 1);
    chk({tag, " bank"}, rsp_bank, exp_bank);
    chk({tag, " ext"}, rsp_ext, exp_ext);
    chk({tag, " R2 offset"}, rsp_off, off);
  endtask

  task automatic expect_map(string tag, logic [7:0] pages, logic [3:0] ext);
    for (int s = 0; s < 4; s++)
      lookup($sformatf("%s slot%0d", tag, s), s, (s * 293 + 17) % 1024,
             pages[2*s +: 2], ext[s]);
  endtask

  task automatic do_mode(logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_sel = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic do_cfg(logic four, logic lock, logic [1:0] m);
    @(negedge clk); cfg_load = 1'b1; cfg_four = four; cfg_lock = lock; cfg_mode = m;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic do_map(logic [7:0] p);
    @(negedge clk); map_wr = 1'b1; map_pages = p;
    @(negedge clk); map_wr = 1'b0;
  endtask

  // Page patterns, slot i in bits 2i+1:2i
  localparam logic [7:0] P_HORZ = 8'b01_01_00_00;
  localparam logic [7:0] P_VERT = 8'b01_00_01_00;
  localparam logic [7:0] P_LO   = 8'b00_00_00_00;
  localparam logic [7:0] P_HI   = 8'b01_01_01_01;
  localparam logic [7:0] P_FOUR = 8'b01_00_01_00;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    expect_map("R1 reset horizontal", P_HORZ, 4'b0000);
  endtask

  task automatic t_modes();
    do_mode(2'd1); expect_map("R4 vertical", P_VERT, 4'b0000);
    do_mode(2'd2); expect_map("R5 single low", P_LO, 4'b0000);
    do_mode(2'd3); expect_map("R5 single high", P_HI, 4'b0000);
    do_mode(2'd0); expect_map("R3 horizontal", P_HORZ, 4'b0000);
  endtask

  task automatic t_four();
    do_cfg(1'b1, 1'b0, 2'd3);
    expect_map("R6 four-screen", P_FOUR, 4'b1100);
    do_map(8'b00_01_10_11);
    expect_map("R9 map keeps ext", 8'b00_01_10_11, 4'b1100);
    do_mode(2'd1);
    expect_map("R8 mode clears ext", P_VERT, 4'b0000);
  endtask

  task automatic t_lock();
    do_cfg(1'b0, 1'b1, 2'd1);
    expect_map("R7 locked cfg vertical", P_VERT, 4'b0000);
    do_mode(2'd3);
    expect_map("R7 locked write ignored", P_VERT, 4'b0000);
    do_map(8'b11_10_01_00);
    expect_map("R9 map under lock", 8'b11_10_01_00, 4'b0000);
    do_cfg(1'b0, 1'b0, 2'd0);
    do_mode(2'd2);
    expect_map("R7 unlocked write applies", P_LO, 4'b0000);
  endtask

  task automatic t_priority();
    @(negedge clk);
    cfg_load = 1'b1; cfg_four = 1'b0; cfg_lock = 1'b0; cfg_mode = 2'd1;
    mode_wr = 1'b1; mode_sel = 2'd3; map_wr = 1'b1; map_pages = 8'hFF;
    @(negedge clk);
    cfg_load = 1'b0; mode_wr = 1'b0; map_wr = 1'b0;
    expect_map("R10 cfg wins", P_VERT, 4'b0000);
    @(negedge clk);
    mode_wr = 1'b1; mode_sel = 2'd3; map_wr = 1'b1; map_pages = 8'hAA;
    @(negedge clk);
    mode_wr = 1'b0; map_wr = 1'b0;
    expect_map("R10 mode beats map", P_HI, 4'b0000);
  endtask

  task automatic t_stall();
    do_cfg(1'b1, 1'b0, 2'd0);
    @(negedge clk);
    req_valid = 1'b1; rsp_ready = 1'b0; req_addr = {2'd2, 10'd100};
    @(negedge clk);
    req_addr = {2'd1, 10'd555};
    chk("R11 stall valid", rsp_valid, 1);
    chk("R11 stall req_ready low", req_ready, 0);
    chk("R11 stall first ext", rsp_ext, 1);
    chk("R11 stall first off", rsp_off, 100);
    @(negedge clk);
    chk("R11 held off", rsp_off, 100);
    chk("R11 held bank", rsp_bank, 0);
    chk("R11 held ext", rsp_ext, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second valid", rsp_valid, 1);
    chk("R11 second off", rsp_off, 555);
    chk("R11 second bank", rsp_bank, 1);
    chk("R11 second ext", rsp_ext, 0);
    @(negedge clk);
    chk("R11 drained", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_four();
    t_lock();
    t_priority();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule